// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block turns the addressing byte of a 16-bit segmented processor instruction into an operand location. The byte has three fields: a 2-bit mode in bits 7:6, a 3-bit register field in bits 5:3 and a 3-bit base/index field in bits 2:0. The block also takes the current base and index registers, the two bytes that follow in the instruction stream, the four segment registers and an optional segment prefix byte.

When the mode field selects a register, the block reports that register's index. Otherwise it returns four things:
- the 16-bit offset;
- the chosen segment, as an identifier and as a value;
- the 20-bit physical address;
- the number of stream bytes used as displacement, and the addressing cost in cycles.

The register field is decoded alongside in every case, so an execution unit can read both operands from a single result.

The calculation runs on the cycle in which `in_valid` is high. The result appears on the registered outputs one clock later. It is marked by a single-cycle `out_valid` and then held until the next request. Instruction fetch and the memory access itself belong to neighbouring logic.

Top module: `seg_ea_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and every result output is 0.
- R2: A request with `in_valid` high gives `out_valid` high on the next clock edge for exactly one cycle. While no request arrives, the result outputs keep their last values.
- R3: For mode 00, 01 and 10, the base/index field selects the registers to sum as follows:
  - 0 → BX+SI
  - 1 → BX+DI
  - 2 → BP+SI
  - 3 → BP+DI
  - 4 → SI
  - 5 → DI
  - 6 → BP (mode 01/10 only)
  - 7 → BX
- R4: Segment identifiers are ES=0, CS=1, SS=2 and DS=3. Without a prefix, any combination that uses BP picks SS, and every other combination picks DS.
- R5: Mode 00 with field 6 is a direct address. The offset is {second byte, first byte}, the segment is DS, and 2 displacement bytes are reported.
- R6: Mode 01 adds the first byte sign-extended to 16 bits and reports 1 byte. Mode 10 adds {second byte, first byte} and reports 2 bytes. Mode 00, except the direct case, reports 0 bytes and adds nothing.
- R7: The offset sum wraps modulo 65536.
- R8: The physical address is (segment value × 16 + offset) modulo 2^20.
- R9: The cost is as follows:
  - Mode 00: 7 for fields 0 and 3; 8 for fields 1 and 2; 5 for fields 4, 5 and 7; 6 for the direct case.
  - Modes 01 and 10: 11 for fields 0 and 3; 12 for fields 1 and 2; 9 for fields 4 to 7.
- R10: A valid prefix byte of 0x26, 0x2E, 0x36 or 0x3E selects ES, CS, SS or DS respectively, in place of the default segment.
- R11: A valid prefix byte with any other value has no effect on the segment choice.
- R12: Mode 11 sets `out_is_reg` to 1, puts bits 2:0 on `out_rm_idx`, and reports 0 displacement bytes and cost 0. Index order for word registers is AX, CX, DX, BX, SP, BP, SI, DI. For byte registers it is AL, CL, DL, BL, AH, CH, DH, BH.
- R13: `out_reg_idx` carries bits 5:3 of the addressing byte in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Request strobe |
| modrm | input | 8 | Addressing byte |
| pfx_valid | input | 1 | Prefix byte present |
| pfx_byte | input | 8 | Prefix byte |
| disp_lo | input | 8 | First stream byte after the addressing byte |
| disp_hi | input | 8 | Second stream byte |
| bx_val | input | 16 | BX register |
| bp_val | input | 16 | BP register |
| si_val | input | 16 | SI register |
| di_val | input | 16 | DI register |
| es_val | input | 16 | ES segment register |
| cs_val | input | 16 | CS segment register |
| ss_val | input | 16 | SS segment register |
| ds_val | input | 16 | DS segment register |
| out_valid | output | 1 | Result strobe |
| out_is_reg | output | 1 | Operand is a register |
| out_rm_idx | output | 3 | Register index from bits 2:0 |
| out_reg_idx | output | 3 | Register index from bits 5:3 |
| out_offset | output | 16 | Effective offset |
| out_seg_id | output | 2 | Chosen segment identifier |
| out_seg_val | output | 16 | Chosen segment value |
| out_phys | output | 20 | Physical address |
| out_disp_len | output | 2 | Displacement bytes consumed |
| out_cost | output | 4 | Addressing cost in cycles |

## Verification
A wrong internal decode shows at the ports on the first result after the request, one clock after `in_valid`. It appears as a mismatch in one of these:
- offset or displacement count, when the base/index or sign-extension logic is wrong;
- segment identifier, when default or override resolution is wrong;
- cost, when the cost table is wrong.

The segment values and base registers in the bench are chosen to be pairwise distinct, so every wrong selection changes the offset or the physical address. A stale or wrongly held register shows as `out_valid` failing to drop on the cycle after the pulse, or as the results changing without a request.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

  // Segment identifiers; the numbering matches bits 4:3 of the prefix bytes.
  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  localparam int unsigned NUM_SEGS = 4;
  localparam int unsigned COST_W   = 4;

  // Addressing cost in cycles for a given mode and base/index field.
  function automatic logic [COST_W-1:0] ea_cost(input logic [1:0] md,
                                                input logic [2:0] rm);
    logic [COST_W-1:0] c;
    if (md == 2'b11) begin
      c = '0;
    end else if (md == 2'b00) begin
      case (rm)
        3'd0, 3'd3: c = 4'd7;
        3'd1, 3'd2: c = 4'd8;
        3'd6:       c = 4'd6;
        default:    c = 4'd5;
      endcase
    end else begin
      case (rm)
        3'd0, 3'd3: c = 4'd11;
        3'd1, 3'd2: c = 4'd12;
        default:    c = 4'd9;
      endcase
    end
    return c;
  endfunction

  // Decodes a segment prefix byte; hit is low for any other byte value.
  function automatic logic pfx_is_seg(input logic [7:0] b);
    return (b[7:5] == 3'b001) && (b[2:0] == 3'b110);
  endfunction

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import seg_ea_pkg::*;
(
  input  logic [7:0]        modrm,
  output logic              is_reg,
  output logic              direct,
  output logic              sel_bx,
  output logic              sel_bp,
  output logic              sel_si,
  output logic              sel_di,
  output logic [1:0]        disp_len,
  output seg_e              dflt_seg,
  output logic [COST_W-1:0] cost
);

  logic [1:0] md;
  logic [2:0] rm;

  assign md = modrm[7:6];
  assign rm = modrm[2:0];

  always_comb begin
    is_reg = (md == 2'b11);
    direct = (md == 2'b00) && (rm == 3'd6);
    sel_bx = !is_reg && ((rm == 3'd0) || (rm == 3'd1) || (rm == 3'd7));
    sel_bp = !is_reg && !direct &&
             ((rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6));
    sel_si = !is_reg && ((rm == 3'd0) || (rm == 3'd2) || (rm == 3'd4));
    sel_di = !is_reg && ((rm == 3'd1) || (rm == 3'd3) || (rm == 3'd5));

    if (is_reg)            disp_len = 2'd0;
    else if (direct)       disp_len = 2'd2;
    else if (md == 2'b01)  disp_len = 2'd1;
    else if (md == 2'b10)  disp_len = 2'd2;
    else                   disp_len = 2'd0;

    dflt_seg = sel_bp ? SEG_SS : SEG_DS;
    cost     = ea_cost(md, rm);
  end

endmodule

// File: rtl/ea_offset_calc.sv
module ea_offset_calc #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              sel_bx,
  input  logic              sel_bp,
  input  logic              sel_si,
  input  logic              sel_di,
  input  logic [1:0]        disp_len,
  input  logic [BYTE_W-1:0] disp_lo,
  input  logic [BYTE_W-1:0] disp_hi,
  input  logic [WORD_W-1:0] bx_val,
  input  logic [WORD_W-1:0] bp_val,
  input  logic [WORD_W-1:0] si_val,
  input  logic [WORD_W-1:0] di_val,
  output logic [WORD_W-1:0] offset
);

  localparam int unsigned EXT_W = WORD_W - BYTE_W;
  localparam int unsigned PAD_W = WORD_W - 2 * BYTE_W;

  logic [WORD_W-1:0] base_part;
  logic [WORD_W-1:0] index_part;
  logic [WORD_W-1:0] disp_short;
  logic [WORD_W-1:0] disp_long;
  logic [WORD_W-1:0] disp_part;

  assign disp_short = {{EXT_W{disp_lo[BYTE_W-1]}}, disp_lo};

  generate
    if (PAD_W > 0) begin : g_pad
      assign disp_long = {{PAD_W{1'b0}}, disp_hi, disp_lo};
    end else begin : g_nopad
      assign disp_long = {disp_hi, disp_lo};
    end
  endgenerate

  always_comb begin
    base_part  = sel_bx ? bx_val : (sel_bp ? bp_val : '0);
    index_part = sel_si ? si_val : (sel_di ? di_val : '0);
    case (disp_len)
      2'd1:    disp_part = disp_short;
      2'd2:    disp_part = disp_long;
      default: disp_part = '0;
    endcase
    offset = base_part + index_part + disp_part;
  end

endmodule

// File: rtl/ea_seg_resolve.sv
module ea_seg_resolve
  import seg_ea_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  seg_e                        dflt_seg,
  input  logic                        pfx_valid,
  input  logic [7:0]                  pfx_byte,
  input  logic [WORD_W-1:0]           es_val,
  input  logic [WORD_W-1:0]           cs_val,
  input  logic [WORD_W-1:0]           ss_val,
  input  logic [WORD_W-1:0]           ds_val,
  input  logic [WORD_W-1:0]           offset,
  output seg_e                        seg_id,
  output logic [WORD_W-1:0]           seg_val,
  output logic [WORD_W+SEG_SHIFT-1:0] phys
);

  localparam int unsigned PHYS_W = WORD_W + SEG_SHIFT;

  logic                  ovr_hit;
  logic [NUM_SEGS-1:0]   seg_oh;
  logic [WORD_W-1:0]     seg_bank [NUM_SEGS];

  assign seg_bank[0] = es_val;
  assign seg_bank[1] = cs_val;
  assign seg_bank[2] = ss_val;
  assign seg_bank[3] = ds_val;

  assign ovr_hit = pfx_valid && pfx_is_seg(pfx_byte);
  assign seg_id  = ovr_hit ? seg_e'(pfx_byte[4:3]) : dflt_seg;

  generate
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_oh
      assign seg_oh[g] = (seg_id == seg_e'(g));
    end
  endgenerate

  always_comb begin
    seg_val = '0;
    for (int k = 0; k < NUM_SEGS; k++) begin
      seg_val = seg_val | (seg_bank[k] & {WORD_W{seg_oh[k]}});
    end
  end

  assign phys = {seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset};

  // R4
  seg_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_oh) == 1);

  // R10
  seg_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit |-> (seg_val == seg_bank[pfx_byte[4:3]]));

  // R11
  seg_noovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_valid || !pfx_is_seg(pfx_byte)) |-> (seg_id == dflt_seg));

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [7:0]                  modrm,
  input  logic                        pfx_valid,
  input  logic [7:0]                  pfx_byte,
  input  logic [7:0]                  disp_lo,
  input  logic [7:0]                  disp_hi,
  input  logic [WORD_W-1:0]           bx_val,
  input  logic [WORD_W-1:0]           bp_val,
  input  logic [WORD_W-1:0]           si_val,
  input  logic [WORD_W-1:0]           di_val,
  input  logic [WORD_W-1:0]           es_val,
  input  logic [WORD_W-1:0]           cs_val,
  input  logic [WORD_W-1:0]           ss_val,
  input  logic [WORD_W-1:0]           ds_val,
  output logic                        out_valid,
  output logic                        out_is_reg,
  output logic [2:0]                  out_rm_idx,
  output logic [2:0]                  out_reg_idx,
  output logic [WORD_W-1:0]           out_offset,
  output logic [1:0]                  out_seg_id,
  output logic [WORD_W-1:0]           out_seg_val,
  output logic [WORD_W+SEG_SHIFT-1:0] out_phys,
  output logic [1:0]                  out_disp_len,
  output logic [COST_W-1:0]           out_cost
);

  localparam int unsigned PHYS_W = WORD_W + SEG_SHIFT;

  logic              dec_is_reg;
  logic              dec_direct;
  logic              dec_bx;
  logic              dec_bp;
  logic              dec_si;
  logic              dec_di;
  logic [1:0]        dec_disp_len;
  seg_e              dec_dflt_seg;
  logic [COST_W-1:0] dec_cost;
  logic [WORD_W-1:0] calc_offset;
  seg_e              res_seg_id;
  logic [WORD_W-1:0] res_seg_val;
  logic [PHYS_W-1:0] res_phys;

  ea_mode_decode u_decode (
    .modrm    (modrm),
    .is_reg   (dec_is_reg),
    .direct   (dec_direct),
    .sel_bx   (dec_bx),
    .sel_bp   (dec_bp),
    .sel_si   (dec_si),
    .sel_di   (dec_di),
    .disp_len (dec_disp_len),
    .dflt_seg (dec_dflt_seg),
    .cost     (dec_cost)
  );

  ea_offset_calc #(.WORD_W(WORD_W)) u_offset (
    .sel_bx   (dec_bx),
    .sel_bp   (dec_bp),
    .sel_si   (dec_si),
    .sel_di   (dec_di),
    .disp_len (dec_disp_len),
    .disp_lo  (disp_lo),
    .disp_hi  (disp_hi),
    .bx_val   (bx_val),
    .bp_val   (bp_val),
    .si_val   (si_val),
    .di_val   (di_val),
    .offset   (calc_offset)
  );

  ea_seg_resolve #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .dflt_seg  (dec_dflt_seg),
    .pfx_valid (pfx_valid),
    .pfx_byte  (pfx_byte),
    .es_val    (es_val),
    .cs_val    (cs_val),
    .ss_val    (ss_val),
    .ds_val    (ds_val),
    .offset    (calc_offset),
    .seg_id    (res_seg_id),
    .seg_val   (res_seg_val),
    .phys      (res_phys)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_is_reg   <= 1'b0;
      out_rm_idx   <= '0;
      out_reg_idx  <= '0;
      out_offset   <= '0;
      out_seg_id   <= '0;
      out_seg_val  <= '0;
      out_phys     <= '0;
      out_disp_len <= '0;
      out_cost     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_is_reg   <= dec_is_reg;
        out_rm_idx   <= modrm[2:0];
        out_reg_idx  <= modrm[5:3];
        out_offset   <= calc_offset;
        out_seg_id   <= res_seg_id;
        out_seg_val  <= res_seg_val;
        out_phys     <= res_phys;
        out_disp_len <= dec_disp_len;
        out_cost     <= dec_cost;
      end
    end
  end

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(out_offset) && $stable(out_phys));

  // R12
  reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_reg |-> (out_disp_len == 2'd0) && (out_cost == '0));

  // R5
  direct_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cost == 4'd6) |-> (out_disp_len == 2'd2));

  // R9
  cost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_reg) |-> (out_cost >= 4'd5));

  // R6
  direct_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_direct) |-> (dec_disp_len == 2'd2) && !dec_bp);

endmodule

// File: tb/seg_ea_gen_tb.sv
module seg_ea_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  modrm = '0;
  logic        pfx_valid = 1'b0;
  logic [7:0]  pfx_byte = '0;
  logic [7:0]  disp_lo = '0;
  logic [7:0]  disp_hi = '0;
  logic [15:0] bx_val = 16'h1234;
  logic [15:0] bp_val = 16'hF000;
  logic [15:0] si_val = 16'h0010;
  logic [15:0] di_val = 16'h2222;
  logic [15:0] es_val = 16'h1000;
  logic [15:0] cs_val = 16'h2000;
  logic [15:0] ss_val = 16'h3000;
  logic [15:0] ds_val = 16'hFFFF;

  logic        out_valid;
  logic        out_is_reg;
  logic [2:0]  out_rm_idx;
  logic [2:0]  out_reg_idx;
  logic [15:0] out_offset;
  logic [1:0]  out_seg_id;
  logic [15:0] out_seg_val;
  logic [19:0] out_phys;
  logic [1:0]  out_disp_len;
  logic [3:0]  out_cost;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seg_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm(modrm),
    .pfx_valid(pfx_valid), .pfx_byte(pfx_byte),
    .disp_lo(disp_lo), .disp_hi(disp_hi),
    .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
    .es_val(es_val), .cs_val(cs_val), .ss_val(ss_val), .ds_val(ds_val),
    .out_valid(out_valid), .out_is_reg(out_is_reg),
    .out_rm_idx(out_rm_idx), .out_reg_idx(out_reg_idx),
    .out_offset(out_offset), .out_seg_id(out_seg_id),
    .out_seg_val(out_seg_val), .out_phys(out_phys),
    .out_disp_len(out_disp_len), .out_cost(out_cost)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] seg_of(input int id);
    case (id)
      0: return es_val;
      1: return cs_val;
      2: return ss_val;
      default: return ds_val;
    endcase
  endfunction

  // Issues one request and compares every result field with a reference.
  task automatic run_case(input string req, input logic [7:0] m,
                          input logic pv, input logic [7:0] pb,
                          input logic [7:0] lo, input logic [7:0] hi);
    int md, rm, seg, cost, len;
    logic [15:0] sum, dsp;
    logic [19:0] ph;
    md = int'(m[7:6]);
    rm = int'(m[2:0]);
    sum = 16'h0;
    dsp = 16'h0;
    len = 0;
    seg = 3;
    if (md != 3) begin
      if (md == 0 && rm == 6) begin
        dsp = {hi, lo}; len = 2;
      end else begin
        case (rm)
          0: sum = bx_val + si_val;
          1: sum = bx_val + di_val;
          2: begin sum = bp_val + si_val; seg = 2; end
          3: begin sum = bp_val + di_val; seg = 2; end
          4: sum = si_val;
          5: sum = di_val;
          6: begin sum = bp_val; seg = 2; end
          default: sum = bx_val;
        endcase
        if (md == 1) begin dsp = {{8{lo[7]}}, lo}; len = 1; end
        if (md == 2) begin dsp = {hi, lo}; len = 2; end
      end
      if (pv) begin
        case (pb)
          8'h26: seg = 0;
          8'h2E: seg = 1;
          8'h36: seg = 2;
          8'h3E: seg = 3;
          default: ;
        endcase
      end
    end
    if (md == 3) cost = 0;
    else if (md == 0 && rm == 6) cost = 6;
    else if (rm == 1 || rm == 2) cost = (md == 0) ? 8 : 12;
    else if (rm == 0 || rm == 3) cost = (md == 0) ? 7 : 11;
    else cost = (md == 0) ? 5 : 9;
    sum = sum + dsp;
    ph = (20'(seg_of(seg)) * 20'd16) + 20'(sum);

    @(negedge clk);
    modrm = m; pfx_valid = pv; pfx_byte = pb; disp_lo = lo; disp_hi = hi;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R2 valid"}, 32'(out_valid), 32'd1);
    chk({req, " R13 reg idx"}, 32'(out_reg_idx), 32'(m[5:3]));
    chk({req, " R12 is_reg"}, 32'(out_is_reg), 32'(md == 3));
    chk({req, " R6 disp len"}, 32'(out_disp_len), 32'(len));
    chk({req, " R9 cost"}, 32'(out_cost), 32'(cost));
    if (md == 3) begin
      chk({req, " R12 rm idx"}, 32'(out_rm_idx), 32'(rm));
    end else begin
      chk({req, " R3 R7 offset"}, 32'(out_offset), 32'(sum));
      chk({req, " R4 R10 seg id"}, 32'(out_seg_id), 32'(seg));
      chk({req, " R8 phys"}, 32'(out_phys), 32'(ph));
    end
    // R2: one-cycle pulse, results held with no request
    @(negedge clk);
    chk({req, " R2 pulse end"}, 32'(out_valid), 32'd0);
    if (md != 3) chk({req, " R2 hold"}, 32'(out_offset), 32'(sum));
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 offset", 32'(out_offset), 32'd0);
    chk("R1 phys", 32'(out_phys), 32'd0);
    chk("R1 cost", 32'(out_cost), 32'd0);
  endtask

  task automatic t_mode0_all();
    for (int r = 0; r < 8; r++)
      run_case("R3 mode00", {2'b00, 3'd5, 3'(r)}, 1'b0, 8'h00, 8'hAA, 8'h55);
  endtask

  task automatic t_mode1_sign();
    run_case("R6 mode01 neg", 8'b01_000_000, 1'b0, 8'h00, 8'hF0, 8'h77);
    run_case("R6 mode01 pos", 8'b01_011_110, 1'b0, 8'h00, 8'h7F, 8'h77);
    for (int r = 0; r < 8; r++)
      run_case("R9 mode01", {2'b01, 3'd2, 3'(r)}, 1'b0, 8'h00, 8'h03, 8'h00);
  endtask

  task automatic t_mode2();
    for (int r = 0; r < 8; r++)
      run_case("R6 mode10", {2'b10, 3'd1, 3'(r)}, 1'b0, 8'h00, 8'h34, 8'h92);
  endtask

  task automatic t_direct();
    run_case("R5 direct", 8'b00_111_110, 1'b0, 8'h00, 8'hCD, 8'hAB);
    run_case("R5 direct ovr", 8'b00_000_110, 1'b1, 8'h36, 8'h01, 8'h80);
  endtask

  task automatic t_wrap();
    // R7: BP(F000)+SI(0010)+2000 wraps past 16 bits
    run_case("R7 wrap", 8'b10_000_010, 1'b0, 8'h00, 8'h00, 8'h20);
    // R8: DS=FFFF pushes the sum past 20 bits
    run_case("R8 phys wrap", 8'b10_000_111, 1'b0, 8'h00, 8'hFF, 8'hFF);
  endtask

  task automatic t_override();
    run_case("R10 es", 8'b00_000_010, 1'b1, 8'h26, 8'h00, 8'h00);
    run_case("R10 cs", 8'b00_000_111, 1'b1, 8'h2E, 8'h00, 8'h00);
    run_case("R10 ss", 8'b01_000_100, 1'b1, 8'h36, 8'h10, 8'h00);
    run_case("R10 ds", 8'b01_000_110, 1'b1, 8'h3E, 8'h10, 8'h00);
  endtask

  task automatic t_ignore();
    run_case("R11 other byte", 8'b00_000_011, 1'b1, 8'h90, 8'h00, 8'h00);
    run_case("R11 near byte", 8'b00_000_001, 1'b1, 8'h27, 8'h00, 8'h00);
    run_case("R11 not valid", 8'b00_000_010, 1'b0, 8'h26, 8'h00, 8'h00);
  endtask

  task automatic t_regmode();
    for (int r = 0; r < 8; r++)
      run_case("R12 regmode", {2'b11, 3'(7 - r), 3'(r)}, 1'b1, 8'h26, 8'h11, 8'h22);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_all();
    t_mode1_sign();
    t_mode2();
    t_direct();
    t_wrap();
    t_override();
    t_ignore();
    t_regmode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule